// File: doc/BRIEF.md
# Accumulator ALU Instruction Executor

This block runs the register-operand arithmetic, logic, rotate and move instructions of a small 8-bit accumulator machine. Each cycle it takes a 13-bit instruction word and the byte read from the register that the word addresses. It works out the result, where the result goes, the new Z, C and DC flags, and whether the next instruction is to be skipped. The accumulator and the three flags are held inside the block. They load on the rising clock edge.

The register file lives outside the block. The executor exports a register address, the write data and a write enable for it. Bits 5..0 of the word name the register. Bits 12..7 choose the operation. Bit 6 chooses the destination: the accumulator or the addressed register. A sequencer outside the block uses the skip output to step over the following word.

Top module: `acc_alu_exec`

## Requirements
- R1: `reg_addr_o` always equals instruction bits 5..0. For the paired operations, bits 12..7 give the operation as follows: 000100 subtract, 000110 decrement, 001000 OR, 001010 AND, 001100 XOR, 001110 add, 010000 move, 010010 complement, 010100 increment, 010110 decrement-skip, 011000 rotate right, 011010 rotate left, 011100 swap, 011110 increment-skip. Bit 6 = 0 raises `acc_we_o` and bit 6 = 1 raises `reg_we_o`. `result_o` carries the value being written.
- R2: `acc_we_o` and `reg_we_o` are never high together. Any word not listed in R1 or R10 (for example 0x000, 0x010, 0x081, 0x1FFF) raises neither enable, holds `skip_o` low and leaves the accumulator and the flags unchanged.
- R3: Subtract computes R minus A. It sets C when R >= A (no borrow) and sets DC when R[3:0] >= A[3:0]. It updates Z, C and DC.
- R4: Add computes R plus A. C takes the carry out of bit 7 and DC takes the carry out of bit 3. It updates Z, C and DC.
- R5: Move, complement, increment, decrement, OR, AND and XOR update only Z. Z = 1 exactly when the 8-bit result is zero. C and DC keep their values.
- R6: Rotate right gives {C, R[7:1]} and loads C from R[0]. Only C changes.
- R7: Rotate left gives {R[6:0], C} and loads C from R[7]. Only C changes.
- R8: Swap gives {R[3:0], R[7:4]} and changes no flag.
- R9: Decrement-skip gives R-1 and increment-skip gives R+1. `skip_o` is high exactly when that 8-bit result is zero. Neither operation changes a flag.
- R10: Bits 12..6 = 0000001 writes A into the register, with no flag change. Bits 12..6 = 0000011 writes 0 into the register and sets Z. The exact word 0x080 clears A and sets Z.
- R11: The accumulator and the flags load on the rising edge and are cleared by synchronous reset. `z_upd_o`, `c_upd_o` and `dc_upd_o` flag which flags the instruction changes. `z_next_o`, `c_next_o` and `dc_next_o` give the value each flag holds after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 13 | Instruction word |
| reg_rdata_i | input | 8 | Value of the addressed register |
| result_o | output | 8 | Result to be written |
| reg_addr_o | output | 6 | Register address for the write |
| acc_we_o | output | 1 | Accumulator loads the result at the edge |
| reg_we_o | output | 1 | External register file writes the result |
| z_next_o | output | 1 | Z after the edge |
| c_next_o | output | 1 | C after the edge |
| dc_next_o | output | 1 | DC after the edge |
| z_upd_o | output | 1 | Instruction changes Z |
| c_upd_o | output | 1 | Instruction changes C |
| dc_upd_o | output | 1 | Instruction changes DC |
| skip_o | output | 1 | Skip the following instruction |
| acc_o | output | 8 | Accumulator |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| dc_o | output | 1 | Digit carry flag |

## Verification
The skip decision and the register write-back can occur in the same cycle. A decrement-skip with bit 6 set, applied to a register holding 1, produces both at once. The bench issues that word, and the increment-skip form on 0xFF, and expects `reg_we_o`, `skip_o` and a zero `result_o` together in one cycle. In the same cycle the flags must hold their earlier values. The accumulator-destination forms with a nonzero result are also issued, to show that the skip is tied to the result and not to the destination.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    localparam int DATA_W  = 8;
    localparam int NIB_W   = DATA_W / 2;
    localparam int ADDR_W  = 6;
    localparam int OPC_W   = 6;
    localparam int INSTR_W = OPC_W + 1 + ADDR_W;

    localparam logic [OPC_W-1:0] OPC_SUB  = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_DEC  = 6'b000110;
    localparam logic [OPC_W-1:0] OPC_OR   = 6'b001000;
    localparam logic [OPC_W-1:0] OPC_AND  = 6'b001010;
    localparam logic [OPC_W-1:0] OPC_XOR  = 6'b001100;
    localparam logic [OPC_W-1:0] OPC_ADD  = 6'b001110;
    localparam logic [OPC_W-1:0] OPC_MOV  = 6'b010000;
    localparam logic [OPC_W-1:0] OPC_COM  = 6'b010010;
    localparam logic [OPC_W-1:0] OPC_INC  = 6'b010100;
    localparam logic [OPC_W-1:0] OPC_DSK  = 6'b010110;
    localparam logic [OPC_W-1:0] OPC_RRC  = 6'b011000;
    localparam logic [OPC_W-1:0] OPC_RLC  = 6'b011010;
    localparam logic [OPC_W-1:0] OPC_SWP  = 6'b011100;
    localparam logic [OPC_W-1:0] OPC_ISK  = 6'b011110;

    localparam logic [OPC_W:0]     XOP_STA   = 7'b0000001;
    localparam logic [OPC_W:0]     XOP_CLRR  = 7'b0000011;
    localparam logic [INSTR_W-1:0] WORD_CLRA = 13'h080;

    typedef enum logic [4:0] {
        OP_NONE, OP_SUB, OP_DEC, OP_OR, OP_AND, OP_XOR, OP_ADD, OP_MOV,
        OP_COM, OP_INC, OP_DSK, OP_RRC, OP_RLC, OP_SWP, OP_ISK,
        OP_STA, OP_CLRR, OP_CLRA
    } alu_op_e;

    typedef struct packed {
        alu_op_e op;
        logic    to_acc;
        logic    to_reg;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              z;
        logic              c;
        logic              dc;
        logic              z_en;
        logic              c_en;
        logic              dc_en;
        logic              skip;
    } alu_res_t;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              z;
        logic              c;
        logic              dc;
    } exec_state_t;
endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output dec_t               dec_o
);
    logic [OPC_W-1:0] opc;
    logic [OPC_W:0]   xopc;
    logic             dst_reg;

    assign opc     = instr_i[INSTR_W-1 -: OPC_W];
    assign xopc    = instr_i[INSTR_W-1 -: OPC_W+1];
    assign dst_reg = instr_i[ADDR_W];

    always_comb begin
        dec_o        = '0;
        dec_o.op     = OP_NONE;
        case (opc)
            OPC_SUB: dec_o.op = OP_SUB;
            OPC_DEC: dec_o.op = OP_DEC;
            OPC_OR:  dec_o.op = OP_OR;
            OPC_AND: dec_o.op = OP_AND;
            OPC_XOR: dec_o.op = OP_XOR;
            OPC_ADD: dec_o.op = OP_ADD;
            OPC_MOV: dec_o.op = OP_MOV;
            OPC_COM: dec_o.op = OP_COM;
            OPC_INC: dec_o.op = OP_INC;
            OPC_DSK: dec_o.op = OP_DSK;
            OPC_RRC: dec_o.op = OP_RRC;
            OPC_RLC: dec_o.op = OP_RLC;
            OPC_SWP: dec_o.op = OP_SWP;
            OPC_ISK: dec_o.op = OP_ISK;
            default: dec_o.op = OP_NONE;
        endcase
        if (dec_o.op != OP_NONE) begin
            dec_o.to_reg = dst_reg;
            dec_o.to_acc = ~dst_reg;
        end
        if (xopc == XOP_STA) begin
            dec_o.op     = OP_STA;
            dec_o.to_reg = 1'b1;
            dec_o.to_acc = 1'b0;
        end else if (xopc == XOP_CLRR) begin
            dec_o.op     = OP_CLRR;
            dec_o.to_reg = 1'b1;
            dec_o.to_acc = 1'b0;
        end else if (instr_i == WORD_CLRA) begin
            dec_o.op     = OP_CLRA;
            dec_o.to_reg = 1'b0;
            dec_o.to_acc = 1'b1;
        end
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] r_i,
    input  logic              c_i,
    output alu_res_t          res_o
);
    logic [DATA_W:0] sum_w;
    logic [DATA_W:0] dif_w;
    logic [NIB_W:0]  nsum_w;
    logic [NIB_W:0]  ndif_w;

    assign sum_w  = {1'b0, r_i} + {1'b0, a_i};
    assign dif_w  = {1'b0, r_i} - {1'b0, a_i};
    assign nsum_w = {1'b0, r_i[NIB_W-1:0]} + {1'b0, a_i[NIB_W-1:0]};
    assign ndif_w = {1'b0, r_i[NIB_W-1:0]} - {1'b0, a_i[NIB_W-1:0]};

    always_comb begin
        res_o = '0;
        case (op_i)
            OP_SUB: begin
                res_o.value = dif_w[DATA_W-1:0];
                res_o.c     = ~dif_w[DATA_W];
                res_o.dc    = ~ndif_w[NIB_W];
                res_o.z_en  = 1'b1;
                res_o.c_en  = 1'b1;
                res_o.dc_en = 1'b1;
            end
            OP_ADD: begin
                res_o.value = sum_w[DATA_W-1:0];
                res_o.c     = sum_w[DATA_W];
                res_o.dc    = nsum_w[NIB_W];
                res_o.z_en  = 1'b1;
                res_o.c_en  = 1'b1;
                res_o.dc_en = 1'b1;
            end
            OP_DEC: begin
                res_o.value = r_i - 1'b1;
                res_o.z_en  = 1'b1;
            end
            OP_INC: begin
                res_o.value = r_i + 1'b1;
                res_o.z_en  = 1'b1;
            end
            OP_OR: begin
                res_o.value = a_i | r_i;
                res_o.z_en  = 1'b1;
            end
            OP_AND: begin
                res_o.value = a_i & r_i;
                res_o.z_en  = 1'b1;
            end
            OP_XOR: begin
                res_o.value = a_i ^ r_i;
                res_o.z_en  = 1'b1;
            end
            OP_MOV: begin
                res_o.value = r_i;
                res_o.z_en  = 1'b1;
            end
            OP_COM: begin
                res_o.value = ~r_i;
                res_o.z_en  = 1'b1;
            end
            OP_DSK: begin
                res_o.value = r_i - 1'b1;
                res_o.skip  = (res_o.value == '0);
            end
            OP_ISK: begin
                res_o.value = r_i + 1'b1;
                res_o.skip  = (res_o.value == '0);
            end
            OP_RRC: begin
                res_o.value = {c_i, r_i[DATA_W-1:1]};
                res_o.c     = r_i[0];
                res_o.c_en  = 1'b1;
            end
            OP_RLC: begin
                res_o.value = {r_i[DATA_W-2:0], c_i};
                res_o.c     = r_i[DATA_W-1];
                res_o.c_en  = 1'b1;
            end
            OP_SWP: begin
                res_o.value = {r_i[NIB_W-1:0], r_i[DATA_W-1:NIB_W]};
            end
            OP_STA: begin
                res_o.value = a_i;
            end
            OP_CLRR, OP_CLRA: begin
                res_o.value = '0;
                res_o.z_en  = 1'b1;
            end
            default: res_o = '0;
        endcase
        res_o.z = (res_o.value == '0);
    end
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
    import acc_alu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [INSTR_W-1:0]   instr_i,
    input  logic [DATA_W-1:0]    reg_rdata_i,
    output logic [DATA_W-1:0]    result_o,
    output logic [ADDR_W-1:0]    reg_addr_o,
    output logic                 acc_we_o,
    output logic                 reg_we_o,
    output logic                 z_next_o,
    output logic                 c_next_o,
    output logic                 dc_next_o,
    output logic                 z_upd_o,
    output logic                 c_upd_o,
    output logic                 dc_upd_o,
    output logic                 skip_o,
    output logic [DATA_W-1:0]    acc_o,
    output logic                 z_o,
    output logic                 c_o,
    output logic                 dc_o
);
    dec_t        dec;
    alu_res_t    alu;
    exec_state_t st_d, st_q;

    acc_alu_decode u_decode (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    acc_alu_core u_core (
        .op_i  (dec.op),
        .a_i   (st_q.acc),
        .r_i   (reg_rdata_i),
        .c_i   (st_q.c),
        .res_o (alu)
    );

    always_comb begin
        st_d = st_q;
        if (dec.to_acc) st_d.acc = alu.value;
        if (alu.z_en)   st_d.z   = alu.z;
        if (alu.c_en)   st_d.c   = alu.c;
        if (alu.dc_en)  st_d.dc  = alu.dc;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign result_o   = alu.value;
    assign reg_addr_o = instr_i[ADDR_W-1:0];
    assign acc_we_o   = dec.to_acc;
    assign reg_we_o   = dec.to_reg;
    assign z_next_o   = st_d.z;
    assign c_next_o   = st_d.c;
    assign dc_next_o  = st_d.dc;
    assign z_upd_o    = alu.z_en;
    assign c_upd_o    = alu.c_en;
    assign dc_upd_o   = alu.dc_en;
    assign skip_o     = alu.skip;
    assign acc_o      = st_q.acc;
    assign z_o        = st_q.z;
    assign c_o        = st_q.c;
    assign dc_o       = st_q.dc;

    assert_single_dest_R2: assert property (@(posedge clk) disable iff (rst)
        !(acc_we_o && reg_we_o));

    assert_skip_zero_R9: assert property (@(posedge clk) disable iff (rst)
        skip_o |-> (result_o == '0));

    assert_acc_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !acc_we_o |=> $stable(acc_o));

    assert_carry_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !c_upd_o |=> $stable(c_o));

    assert_dc_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !dc_upd_o |=> $stable(dc_o));

    assert_clear_acc_R10: assert property (@(posedge clk) disable iff (rst)
        (instr_i == WORD_CLRA) |=> (acc_o == '0 && z_o));

    assert_rrc_carry_R6: assert property (@(posedge clk) disable iff (rst)
        (instr_i[INSTR_W-1 -: OPC_W] == OPC_RRC) |=> (c_o == $past(reg_rdata_i[0])));
endmodule

// File: tb/tb_acc_alu_exec.sv
module tb_acc_alu_exec;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] instr_i = '0;
    logic [7:0]  reg_rdata_i = '0;
    logic [7:0]  result_o, acc_o;
    logic [5:0]  reg_addr_o;
    logic        acc_we_o, reg_we_o, skip_o;
    logic        z_next_o, c_next_o, dc_next_o, z_upd_o, c_upd_o, dc_upd_o;
    logic        z_o, c_o, dc_o;

    always #5 clk = ~clk;

    acc_alu_exec dut (
        .clk(clk), .rst(rst), .instr_i(instr_i), .reg_rdata_i(reg_rdata_i),
        .result_o(result_o), .reg_addr_o(reg_addr_o), .acc_we_o(acc_we_o),
        .reg_we_o(reg_we_o), .z_next_o(z_next_o), .c_next_o(c_next_o),
        .dc_next_o(dc_next_o), .z_upd_o(z_upd_o), .c_upd_o(c_upd_o),
        .dc_upd_o(dc_upd_o), .skip_o(skip_o), .acc_o(acc_o), .z_o(z_o),
        .c_o(c_o), .dc_o(dc_o)
    );

    typedef struct {
        logic [7:0] res;
        logic [5:0] addr;
        bit         awe, rwe, skip, zu, cu, du;
        logic [7:0] acc;
        bit         z, c, dc;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;
    logic [7:0] m_a = 0;
    bit   m_z = 0, m_c = 0, m_dc = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [6:0] x, input logic [5:0] ad,
                         input logic [7:0] r, input string tag);
        exp_t e;
        logic [8:0] t9;
        logic [7:0] v;
        bit valid, zu, cu, du, sk, nc, ndc, awe, rwe;
        valid = 1; v = 0; zu = 0; cu = 0; du = 0; sk = 0; nc = m_c; ndc = m_dc;
        case (x[6:1])
            6'b000100: begin v = r - m_a; nc = (r >= m_a); ndc = (r[3:0] >= m_a[3:0]);
                             zu = 1; cu = 1; du = 1; end
            6'b001110: begin t9 = {1'b0, r} + {1'b0, m_a}; v = t9[7:0]; nc = t9[8];
                             ndc = (({1'b0, r[3:0]} + {1'b0, m_a[3:0]}) > 5'd15);
                             zu = 1; cu = 1; du = 1; end
            6'b000110: begin v = r - 8'd1; zu = 1; end
            6'b001000: begin v = r | m_a; zu = 1; end
            6'b001010: begin v = r & m_a; zu = 1; end
            6'b001100: begin v = r ^ m_a; zu = 1; end
            6'b010000: begin v = r; zu = 1; end
            6'b010010: begin v = ~r; zu = 1; end
            6'b010100: begin v = r + 8'd1; zu = 1; end
            6'b010110: begin v = r - 8'd1; sk = (v == 0); end
            6'b011110: begin v = r + 8'd1; sk = (v == 0); end
            6'b011000: begin v = {m_c, r[7:1]}; nc = r[0]; cu = 1; end
            6'b011010: begin v = {r[6:0], m_c}; nc = r[7]; cu = 1; end
            6'b011100: begin v = {r[3:0], r[7:4]}; end
            default:   valid = 0;
        endcase
        awe = valid & ~x[0];
        rwe = valid & x[0];
        if (x == 7'b0000001) begin v = m_a; rwe = 1; awe = 0; end
        if (x == 7'b0000011) begin v = 0; zu = 1; rwe = 1; awe = 0; end
        if ({x, ad} == 13'h080) begin v = 0; zu = 1; awe = 1; rwe = 0; end
        if (awe) m_a = v;
        if (zu) m_z = (v == 0);
        m_c = nc;
        m_dc = ndc;
        e.res = v; e.addr = ad; e.awe = awe; e.rwe = rwe; e.skip = sk;
        e.zu = zu; e.cu = cu; e.du = du; e.acc = m_a; e.z = m_z; e.c = m_c;
        e.dc = m_dc; e.tag = tag;
        @(negedge clk);
        instr_i = {x, ad};
        reg_rdata_i = r;
        q.push_back(e);
    endtask

    // monitor: outputs of the current word at negedge+3, registered state after the edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #3;
            if (q.size() > 0) begin
                e = q.pop_front();
                check(acc_we_o == e.awe, e.tag, "acc_we", acc_we_o, e.awe);
                check(reg_we_o == e.rwe, e.tag, "reg_we", reg_we_o, e.rwe);
                check(skip_o == e.skip, e.tag, "skip", skip_o, e.skip);
                check(reg_addr_o == e.addr, e.tag, "addr", reg_addr_o, e.addr);
                check({z_upd_o, c_upd_o, dc_upd_o} == {e.zu, e.cu, e.du}, e.tag,
                      "flag_upd", {z_upd_o, c_upd_o, dc_upd_o}, {e.zu, e.cu, e.du});
                check({z_next_o, c_next_o, dc_next_o} == {e.z, e.c, e.dc}, e.tag,
                      "flag_next", {z_next_o, c_next_o, dc_next_o}, {e.z, e.c, e.dc});
                if (e.awe || e.rwe)
                    check(result_o == e.res, e.tag, "result", result_o, e.res);
                @(posedge clk);
                #1;
                check(acc_o == e.acc, e.tag, "acc", acc_o, e.acc);
                check({z_o, c_o, dc_o} == {e.z, e.c, e.dc}, e.tag, "flags",
                      {z_o, c_o, dc_o}, {e.z, e.c, e.dc});
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        instr_i = 13'h1D05;
        reg_rdata_i = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        instr_i = 13'h000;
        #1;
        check(acc_o == 0 && {z_o, c_o, dc_o} == 3'b000, "R11", "reset state",
              {acc_o, z_o, c_o, dc_o}, 0);

        issue(7'b0100000, 6'h05, 8'h35, "R5 mov A");
        issue(7'b0011100, 6'h06, 8'hCB, "R4 add wrap");
        issue(7'b0100000, 6'h07, 8'h0F, "R5 mov A");
        issue(7'b0011101, 6'h08, 8'h01, "R4 add to reg");
        issue(7'b0001000, 6'h09, 8'h0F, "R3 sub equal");
        issue(7'b0100000, 6'h0A, 8'h20, "R5 mov A");
        issue(7'b0001001, 6'h0B, 8'h10, "R3 sub borrow to reg");
        issue(7'b0001000, 6'h0C, 8'h21, "R3 sub no borrow");
        issue(7'b0001000, 6'h0D, 8'h00, "R3 sub borrow");
        issue(7'b0011100, 6'h0E, 8'h0F, "R4 add nibble carry");
        issue(7'b0010000, 6'h0F, 8'hF0, "R5 or");
        issue(7'b0010101, 6'h10, 8'h0F, "R5 and to reg");
        issue(7'b0011000, 6'h11, 8'h0E, "R5 xor");
        issue(7'b0100100, 6'h12, 8'hFF, "R5 com zero");
        issue(7'b0101001, 6'h13, 8'hFF, "R5 inc to reg");
        issue(7'b0001100, 6'h14, 8'h01, "R5 dec");
        issue(7'b0110000, 6'h15, 8'h81, "R6 rrc");
        issue(7'b0110001, 6'h16, 8'h02, "R6 rrc carry in");
        issue(7'b0110100, 6'h17, 8'h80, "R7 rlc");
        issue(7'b0110101, 6'h18, 8'h40, "R7 rlc carry in");
        issue(7'b0111000, 6'h19, 8'hA5, "R8 swap");
        issue(7'b0111001, 6'h1A, 8'h3C, "R8 swap to reg");
        issue(7'b0101101, 6'h1B, 8'h01, "R9 dec skip to reg");
        issue(7'b0101100, 6'h1C, 8'h05, "R9 dec no skip");
        issue(7'b0111101, 6'h1D, 8'hFF, "R9 inc skip to reg");
        issue(7'b0111100, 6'h1E, 8'h10, "R9 inc no skip");
        issue(7'b0100000, 6'h1F, 8'h77, "R1 mov A");
        issue(7'b0000001, 6'h20, 8'h00, "R10 store A");
        issue(7'b0000011, 6'h21, 8'h55, "R10 clear reg");
        issue(7'b0100000, 6'h22, 8'h99, "R1 mov A");
        issue(7'b0000010, 6'h00, 8'h99, "R10 clear A");
        issue(7'b0100000, 6'h23, 8'h42, "R1 mov A");
        issue(7'b0110100, 6'h24, 8'h80, "R7 set carry");
        issue(7'b0000000, 6'h00, 8'h00, "R2 unlisted 000");
        issue(7'b0000000, 6'h10, 8'h00, "R2 unlisted 010");
        issue(7'b0000010, 6'h01, 8'h00, "R2 unlisted 081");
        issue(7'b1111111, 6'h3F, 8'h00, "R2 unlisted 1FFF");
        @(negedge clk);
        instr_i = 13'h000;
        wait (q.size() == 0);
        repeat (2) @(posedge clk);
        #1;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule